// File: doc/BRIEF.md
# Video Activity Persistence Counter

This block measures how long video activity keeps a retriggerable speedup timer alive. Every trigger of that speedup timer starts a watch timer of a fixed number of millisecond ticks, 100 by default. The watch timer may run out while the speedup timer is still active. When that happens, a 16-bit persistence count goes up by one and the watch timer starts again. When the speedup timer lapses, the watch timer stops and nothing is counted.

Software reads the count and clears it whenever it wants to start a new evaluation window. The count stops at its maximum value instead of wrapping to zero. The speedup timer itself lives outside this block. The block only sees its trigger strobe and its active flag.

Top module: `vid_persist_top`

## Requirements
- R1: After reset, `persist_cnt` is 0 and the watch timer is idle.
- R2: A pulse on `spd_trig` in a cycle where `clr` is low loads the watch timer with zero elapsed ticks and starts it. This also applies when the watch timer is already running.
- R3: While `spd_active` stays high, each WINDOW_TICKS `tick_1ms` pulses after the start make `persist_cnt` increase by exactly 1. The increment is visible one cycle after the tick that completes the window.
- R4: After an increment, the watch timer restarts and counts another full window, so that N windows give N increments.
- R5: While the watch timer is running, a cycle with `spd_active` low stops it without any increment. No further increments happen until the next `spd_trig`.
- R6: `persist_cnt` saturates at its all-ones value. It never wraps.
- R7: When `clr` is high, `persist_cnt` reads 0 in the next cycle. The clear wins over an increment in the same cycle.
- R8: `tick_1ms` pulses while the watch timer is idle have no effect on `persist_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse once per millisecond |
| spd_trig | input | 1 | The speedup timer was triggered (re)loaded |
| spd_active | input | 1 | The speedup timer is still counting |
| clr | input | 1 | Software clear of the count |
| persist_cnt | output | CNT_W | Persistence count |

## Verification
The bench builds the block with WINDOW_TICKS=5 and CNT_W=4. This lets it sweep every window outcome and reach saturation at 15 within a few hundred ticks. For each run length in ticks it computes the expected count as floor(length/5), capped at 15. The bench also checks retrigger timing partway through a window, a clear arriving together with an increment, and ticks that arrive while the watch timer is idle.

// File: rtl/vid_persist_pkg.sv
package vid_persist_pkg;
  typedef enum logic [0:0] {WATCH_IDLE = 1'b0, WATCH_RUN = 1'b1} watch_st_e;
endpackage

// File: rtl/vid_watch_timer.sv
module vid_watch_timer
  import vid_persist_pkg::*;
#(
  parameter int WINDOW_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1ms,
  input  logic start,
  input  logic active,
  output logic window_done,
  output logic running
);
  localparam int TW = (WINDOW_TICKS > 1) ? $clog2(WINDOW_TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(WINDOW_TICKS - 1);

  watch_st_e st_q, st_d;
  logic [TW-1:0] ticks_q, ticks_d;
  logic ticks_en;

  always_comb begin
    st_d        = st_q;
    ticks_d     = ticks_q;
    ticks_en    = 1'b0;
    window_done = 1'b0;
    if (start) begin
      st_d     = WATCH_RUN;
      ticks_d  = '0;
      ticks_en = 1'b1;
    end else if (st_q == WATCH_RUN) begin
      if (!active) begin
        st_d     = WATCH_IDLE;
        ticks_d  = '0;
        ticks_en = 1'b1;
      end else if (tick_1ms) begin
        ticks_en = 1'b1;
        if (ticks_q == LAST) begin
          window_done = 1'b1;
          ticks_d     = '0;
        end else begin
          ticks_d = ticks_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WATCH_IDLE;
      ticks_q <= '0;
    end else begin
      st_q <= st_d;
      if (ticks_en) ticks_q <= ticks_d;
    end
  end

  assign running = (st_q == WATCH_RUN);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WATCH_IDLE) |-> !window_done);
  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && ticks_q == '0));
  // R5
  lapse_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !active) |=> !running);
endmodule

// File: rtl/vid_sat_counter.sv
module vid_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (inc && cnt_q != MAXV) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R7
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAXV && !clr) |=> (count == MAXV));
  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(count));
endmodule

// File: rtl/vid_persist_top.sv
module vid_persist_top #(
  parameter int WINDOW_TICKS = 100,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1ms,
  input  logic             spd_trig,
  input  logic             spd_active,
  input  logic             clr,
  output logic [CNT_W-1:0] persist_cnt
);
  logic window_done, running;

  vid_watch_timer #(.WINDOW_TICKS(WINDOW_TICKS)) u_watch (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .start(spd_trig),
    .active(spd_active), .window_done(window_done), .running(running)
  );

  vid_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(window_done), .clr(clr), .count(persist_cnt)
  );

  // R8
  idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !spd_trig && !clr) |=> $stable(persist_cnt));
endmodule

// File: tb/vid_persist_top_test.sv
module vid_persist_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int WT = 5;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0, tick = 0, trig = 0, act = 0, clr = 0;
  logic [CW-1:0] cnt;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  vid_persist_top #(.WINDOW_TICKS(WT), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .spd_trig(trig),
    .spd_active(act), .clr(clr), .persist_cnt(cnt));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int exp);
    n_run++;
    if (int'(cnt) != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, cnt, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic pulse_tick(); tick = 1; cyc(); tick = 0; cyc(); endtask
  task automatic do_clr(); clr = 1; cyc(); clr = 0; endtask
  task automatic start_run(); act = 1; trig = 1; cyc(); trig = 0; endtask
  task automatic stop_run(); act = 0; cyc(); cyc(); endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    chk("R1", 0);
    rst_n = 1; cyc();
    chk("R1", 0);
    // R8 ticks while idle
    for (int i = 0; i < 12; i++) pulse_tick();
    chk("R8", 0);
    // R3 R4 R6 sweep of run lengths
    for (int len = 0; len <= 90; len += 3) begin
      int e;
      do_clr();
      start_run();
      for (int i = 0; i < len; i++) pulse_tick();
      e = len / WT; if (e > 15) e = 15;
      chk(len > 80 ? "R6" : (len >= 2*WT ? "R4" : "R3"), e);
      stop_run();
      for (int i = 0; i < 7; i++) pulse_tick();
      chk("R5", e);
    end
    // R2 retrigger mid-window restarts
    do_clr();
    start_run();
    for (int i = 0; i < WT-1; i++) pulse_tick();
    trig = 1; cyc(); trig = 0;
    for (int i = 0; i < WT-1; i++) pulse_tick();
    chk("R2", 0);
    pulse_tick();
    chk("R2", 1);
    // R5 lapse mid-window then ticks
    act = 0; cyc(); act = 1;
    for (int i = 0; i < 3*WT; i++) pulse_tick();
    chk("R5", 1);
    // R7 clear on the increment cycle
    start_run();
    for (int i = 0; i < WT-1; i++) pulse_tick();
    tick = 1; clr = 1; cyc(); tick = 0; clr = 0;
    chk("R7", 0);
    for (int i = 0; i < WT; i++) pulse_tick();
    chk("R4", 1);
    stop_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule